// File: doc/BRIEF.md
# Fixed-Point Multiply-Add Pipeline

This block evaluates A = B×C + D on signed two's complement operands held in fixed-point form. Each operand has a known magnitude bound. Each one's binary point is placed to give the finest resolution that still holds that bound in an 8-bit word. B and C use two integer bits (sign included) and six fraction bits. D uses three integer bits and five fraction bits. The 8-bit result carries four integer bits and four fraction bits, which covers every sum the bounds allow.

Inside, the block keeps the product of B and C at full width. It sign-extends both addends and moves D's binary point to line up with the product's. It adds them at the wider fraction count, then drops low fraction bits to reach the output word. The operands are captured in an input register. A multiply register and an add-and-truncate register follow, and a valid flag travels alongside the data. The output register keeps its last result until the next valid item arrives.

Top module: `fxp_mac_unit`

## Requirements
- R1: While reset is high, and on the first edge after it is raised, `out_valid` becomes 0 and `out_a` becomes 0x00.
- R2: An item presented with `in_valid` high before clock edge k appears with `out_valid` high after edge k+2, which is three edges in total. A new item may be accepted on every cycle, and results leave in the order they entered.
- R3: `in_b` and `in_c` are read as signed raw/64, and `in_d` as signed raw/32. `out_a` is signed raw/16.
- R4: The product B×C is formed exactly at 16 bits with 12 fraction bits. D is sign-extended and shifted left by 7 places so that its fraction count matches before the add.
- R5: The result is the exact sum with its 8 lowest fraction bits discarded, which means it rounds toward minus infinity. For example, B=-1/64, C=1/64, D=0 gives 0xFF.
- R6: At the bound corners the result is exact with no overflow. B=115, C=64, D=89 gives 0x49 (73), and B=-115, C=64, D=-89 gives 0xB6 (-74).
- R7: When `out_valid` is low, `out_a` keeps the value of the most recent valid result. Cycles with `in_valid` low change nothing in the data path.
- R8: Every 8-bit input pattern, including -128 × -128 with D=127, gives the floor of the sum in 4.4 form without wrap. That case gives 0x7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operands as a new item |
| in_b | input | 8 | Multiplier B, signed 2.6 |
| in_c | input | 8 | Multiplicand C, signed 2.6 |
| in_d | input | 8 | Addend D, signed 3.5 |
| out_valid | output | 1 | Marks `out_a` as a new result |
| out_a | output | 8 | Result A, signed 4.4 |

## Verification
The hardest situation to reach from the ports is a sum that is negative and not a multiple of 1/16. Only that case separates floor truncation from rounding or from truncation toward zero. Uniform random operands seldom land on a tiny negative remainder. The stimulus therefore adds directed single-LSB products of each sign next to the bound corners. Gaps in `in_valid` are drawn at random, so the hold behaviour and the order of results are checked across bubbles of different lengths.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  localparam int unsigned DEF_IN_W    = 8;
  localparam int unsigned DEF_B_FRAC  = 6;
  localparam int unsigned DEF_C_FRAC  = 6;
  localparam int unsigned DEF_D_FRAC  = 5;
  localparam int unsigned DEF_OUT_W   = 8;
  localparam int unsigned DEF_OUT_FRAC = 4;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fxp_in_reg.sv
module fxp_in_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] c_o,
  output logic [W-1:0] d_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      b_o   <= '0;
      c_o   <= '0;
      d_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        b_o <= b_i;
        c_o <= c_i;
        d_o <= d_i;
      end
    end
  end
endmodule

// File: rtl/fxp_mul_stage.sv
module fxp_mul_stage #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  output logic          vld_o,
  output logic [PW-1:0] prod_o,
  output logic [W-1:0]  d_o
);
  logic signed [PW-1:0] prod_full;

  always_comb begin
    prod_full = PW'($signed(b_i)) * PW'($signed(c_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      prod_o <= '0;
      d_o    <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        prod_o <= prod_full;
        d_o    <= d_i;
      end
    end
  end
endmodule

// File: rtl/fxp_add_trunc.sv
module fxp_add_trunc #(
  parameter int unsigned W        = 8,
  parameter int unsigned PW       = 16,
  parameter int unsigned P_SHIFT  = 0,
  parameter int unsigned D_SHIFT  = 7,
  parameter int unsigned SUM_W    = 17,
  parameter int unsigned DROP     = 8,
  parameter int unsigned OUT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld_i,
  input  logic [PW-1:0]    prod_i,
  input  logic [W-1:0]     d_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] a_o
);
  logic signed [SUM_W-1:0] p_al;
  logic signed [SUM_W-1:0] d_al;
  logic signed [SUM_W-1:0] sum;

  generate
    if (P_SHIFT == 0) begin : g_p_pass
      always_comb p_al = SUM_W'($signed(prod_i));
    end else begin : g_p_shift
      always_comb p_al = SUM_W'($signed(prod_i)) <<< P_SHIFT;
    end
    if (D_SHIFT == 0) begin : g_d_pass
      always_comb d_al = SUM_W'($signed(d_i));
    end else begin : g_d_shift
      always_comb d_al = SUM_W'($signed(d_i)) <<< D_SHIFT;
    end
  endgenerate

  always_comb sum = p_al + d_al;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      a_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) a_o <= sum[DROP +: OUT_W];
    end
  end
endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit
  import fxp_mac_pkg::*;
#(
  parameter int unsigned IN_W     = DEF_IN_W,
  parameter int unsigned B_FRAC   = DEF_B_FRAC,
  parameter int unsigned C_FRAC   = DEF_C_FRAC,
  parameter int unsigned D_FRAC   = DEF_D_FRAC,
  parameter int unsigned OUT_W    = DEF_OUT_W,
  parameter int unsigned OUT_FRAC = DEF_OUT_FRAC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_b,
  input  logic [IN_W-1:0] in_c,
  input  logic [IN_W-1:0] in_d,
  output logic            out_valid,
  output logic [OUT_W-1:0] out_a
);
  localparam int unsigned PW        = 2 * IN_W;
  localparam int unsigned P_FRAC    = B_FRAC + C_FRAC;
  localparam int unsigned P_INT     = PW - P_FRAC;
  localparam int unsigned D_INT     = IN_W - D_FRAC;
  localparam int unsigned AL_FRAC   = max2(P_FRAC, D_FRAC);
  localparam int unsigned AL_INT    = max2(P_INT, D_INT) + 1;
  localparam int unsigned SUM_W     = AL_INT + AL_FRAC;
  localparam int unsigned P_SHIFT   = AL_FRAC - P_FRAC;
  localparam int unsigned D_SHIFT   = AL_FRAC - D_FRAC;
  localparam int unsigned DROP      = AL_FRAC - OUT_FRAC;

  logic            s0_vld;
  logic [IN_W-1:0] s0_b, s0_c, s0_d;
  logic            s1_vld;
  logic [PW-1:0]   s1_prod;
  logic [IN_W-1:0] s1_d;

  fxp_in_reg #(.W(IN_W)) u_in (
    .clk(clk), .rst(rst), .vld_i(in_valid),
    .b_i(in_b), .c_i(in_c), .d_i(in_d),
    .vld_o(s0_vld), .b_o(s0_b), .c_o(s0_c), .d_o(s0_d)
  );

  fxp_mul_stage #(.W(IN_W)) u_mul (
    .clk(clk), .rst(rst), .vld_i(s0_vld),
    .b_i(s0_b), .c_i(s0_c), .d_i(s0_d),
    .vld_o(s1_vld), .prod_o(s1_prod), .d_o(s1_d)
  );

  fxp_add_trunc #(
    .W(IN_W), .PW(PW), .P_SHIFT(P_SHIFT), .D_SHIFT(D_SHIFT),
    .SUM_W(SUM_W), .DROP(DROP), .OUT_W(OUT_W)
  ) u_add (
    .clk(clk), .rst(rst), .vld_i(s1_vld),
    .prod_i(s1_prod), .d_i(s1_d),
    .vld_o(out_valid), .a_o(out_a)
  );
endmodule

// File: rtl/fxp_mac_chk.sv
module fxp_mac_chk #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned D_SHIFT = 7,
  parameter int unsigned DROP    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_b,
  input logic [IN_W-1:0]  in_c,
  input logic [IN_W-1:0]  in_d,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_a
);
  logic [2:0]       vpipe;
  logic [OUT_W-1:0] ref_q [3];

  function automatic logic [OUT_W-1:0] ref_val(input logic [IN_W-1:0] b,
                                               input logic [IN_W-1:0] c,
                                               input logic [IN_W-1:0] d);
    int full;
    full = int'($signed(b)) * int'($signed(c)) + int'($signed(d)) * (1 << D_SHIFT);
    return OUT_W'(full >>> DROP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
      for (int i = 0; i < 3; i++) ref_q[i] <= '0;
    end else begin
      vpipe <= {vpipe[1:0], in_valid};
      ref_q[0] <= ref_val(in_b, in_c, in_d);
      ref_q[1] <= ref_q[0];
      ref_q[2] <= ref_q[1];
    end
  end

  // R1: reset clears the output register and the valid flag
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_a == '0));

  // R2: valid leaves three edges after it entered
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[2]);

  // R5, R6, R8: valid result equals the floor of the exact sum
  assert_value_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_a == ref_q[2]);

  // R7: result holds while no valid item leaves
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_a));
endmodule

bind fxp_mac_unit fxp_mac_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .D_SHIFT(D_SHIFT), .DROP(DROP)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_b(in_b), .in_c(in_c),
  .in_d(in_d), .out_valid(out_valid), .out_a(out_a)
);

// File: tb/sim_fxp_mac_unit.sv
module sim_fxp_mac_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_b = '0, in_c = '0, in_d = '0;
  logic       out_valid;
  logic [7:0] out_a;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       h_v [3];
  logic [7:0] h_e [3];
  logic [7:0] last_res = 8'h00;

  always #2.5 clk = ~clk;

  fxp_mac_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_b(in_b), .in_c(in_c),
    .in_d(in_d), .out_valid(out_valid), .out_a(out_a)
  );

  // B, C raw/64; D raw/32; full sum in 2^-12 units; result floor in 2^-4 units
  function automatic logic [7:0] model(input logic [7:0] b, input logic [7:0] c,
                                       input logic [7:0] d);
    int full;
    full = int'($signed(b)) * int'($signed(c)) + int'($signed(d)) * 128;
    return 8'(full >>> 8);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: check what left, then drive the next item (all at negedge)
  task automatic step(input string req, input logic v, input logic [7:0] b,
                      input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    check("R2", {7'd0, out_valid}, {7'd0, h_v[2]});
    if (h_v[2]) begin
      check(req, out_a, h_e[2]);
      last_res = h_e[2];
    end else begin
      check("R7", out_a, last_res);
    end
    h_v[2] = h_v[1]; h_e[2] = h_e[1];
    h_v[1] = h_v[0]; h_e[1] = h_e[0];
    h_v[0] = v;      h_e[0] = model(b, c, d);
    in_valid = v; in_b = b; in_c = c; in_d = d;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin h_v[i] = 1'b0; h_e[i] = '0; end
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    check("R1", {7'd0, out_valid}, 8'd0);
    check("R1", out_a, 8'h00);
    rst = 1'b0;

    step("R4", 1'b1, 8'd0,   8'd0,   8'd0);      // zero
    step("R3", 1'b1, 8'd64,  8'd64,  8'd0);      // 1.0*1.0 -> 0x10
    step("R5", 1'b1, 8'd1,   8'd1,   8'd0);      // +2^-12 -> 0x00
    step("R5", 1'b1, 8'hFF,  8'd1,   8'd0);      // -2^-12 -> 0xFF
    step("R6", 1'b1, 8'd115, 8'd64,  8'd89);     // 0x49
    step("R6", 1'b1, 8'h8D,  8'd64,  8'hA7);     // -115,-89 -> 0xB6
    step("R4", 1'b1, 8'd0,   8'd0,   8'd32);     // D = 1.0 -> 0x10
    step("R8", 1'b1, 8'h80,  8'h80,  8'd127);    // 0x7F
    step("R8", 1'b1, 8'h80,  8'd127, 8'h80);     // -> 0x80
    step("R3", 1'b1, 8'd64,  8'hC0,  8'd0);      // -1.0 -> 0xF0
    // Bubble with garbage operands: must not disturb the held result
    step("R7", 1'b0, 8'h7F,  8'h7F,  8'h7F);
    step("R7", 1'b0, 8'h55,  8'hAA,  8'h33);
    step("R7", 1'b0, 8'h12,  8'h34,  8'h56);
    step("R7", 1'b0, 8'h00,  8'h00,  8'h00);

    for (int n = 0; n < 400; n++) begin
      int b, c, d;
      logic v;
      b = int'($urandom_range(230)) - 115;
      c = int'($urandom_range(128)) - 64;
      d = int'($urandom_range(178)) - 89;
      v = ($urandom_range(3) != 0);
      step("R5", v, 8'(b), 8'(c), 8'(d));
    end
    for (int n = 0; n < 4; n++) step("R2", 1'b0, 8'h00, 8'h00, 8'h00);

    // R1: reset mid-stream clears state
    @(negedge clk);
    in_valid = 1'b1; in_b = 8'd64; in_c = 8'd64; in_d = 8'd32;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", {7'd0, out_valid}, 8'd0);
    check("R1", out_a, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 20000);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule